// File: doc/BRIEF.md
# Byte Mailbox Command Processor

This block is a peripheral-side command engine that a host reaches over a narrow byte-wide register bus. The host loads argument bytes into an outgoing mailbox and then writes a command code. That write starts execution. When the command finishes, the engine copies the code into incoming status byte 2. The host polls that byte until it matches the code it issued, then reads the result bytes.

The engine handles some commands itself: relay control, relay readback, firmware and hardware version queries, and an echo-clear command that also samples the isolated inputs. Counter, filter and pattern commands go to external sub-blocks over a request/acknowledge pair, and the sub-block's 16-bit answer is returned in the mailbox. The engine drives eight relay outputs and samples eight isolated inputs through a synchroniser.

The status byte keeps the last completed code. Issuing the clear command between two identical commands therefore lets the host see the second one finish.

Top module: `mbox_cmd_engine`

## Requirements
- R1: After a synchronous reset, the relay outputs are 0x00, sub_req is low, and all four incoming bytes read back as 0x00.
- R2: A write to outgoing address 2 starts a command. For a locally decoded or unknown code, incoming byte 2 takes the code on the fourth rising edge after the edge that accepted the write.
- R3: Code 0x00 sets incoming byte 2 to 0x00 and loads incoming byte 3 with the isolated inputs, taken after a two-flop synchroniser. Incoming bytes 0 and 1 are left unchanged.
- R4: Code 0x01 sets the relay outputs to outgoing byte 0. Code 0x02 copies the relay state into incoming byte 0. No other code changes the relays.
- R5: Code 0x0E returns the firmware version (default 0x0A17) and code 0x0F returns the hardware version (default 0x0B02), high byte in incoming byte 1 and low byte in incoming byte 0.
- R6: Codes 0x20–0x2F and 0x40–0x4F raise sub_req with sub_cmd equal to the code and sub_arg equal to outgoing byte 1 × 256 + outgoing byte 0. sub_req stays high until sub_ack is sampled high. On that edge the command completes: sub_rdata high byte goes to incoming byte 1, its low byte to incoming byte 0, and the code to incoming byte 2.
- R7: Any other code completes after the fixed latency with no effect except writing its code into incoming byte 2. It never raises sub_req.
- R8: While a command is executing, bus writes to every outgoing address are ignored: they neither change the argument bytes nor start a new command.
- R9: Incoming byte 2 holds the last completed code until another command completes. A repeated identical code leaves it unchanged, and an intervening 0x00 makes the repeat observable.
- R10: rd_data presents the incoming byte selected by rd_addr, registered, one rising edge after the byte's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Outgoing mailbox write strobe |
| wr_addr | input | 2 | Outgoing byte index (2 = command) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Incoming byte index |
| rd_data | output | 8 | Registered incoming byte |
| iso_in | input | 8 | Asynchronous isolated inputs |
| relay_out | output | 8 | Relay drive |
| sub_req | output | 1 | Forwarded command request |
| sub_cmd | output | 8 | Forwarded command code |
| sub_arg | output | 16 | Forwarded 16-bit argument |
| sub_ack | input | 1 | Sub-block completion |
| sub_rdata | input | 16 | Sub-block result |

## Verification
The bench targets the following corner cases:

- **Completion edge.** The bench pins the exact edge on which the echo appears. An engine that is off by one cycle shows the code too early or too late on the read port.
- **Repeat-then-clear.** A design that cleared the echo on every start, or never held it, would break the host's ability to see two identical commands finish.
- **Writes while busy.** The bench hammers argument and command writes while a command is in flight. A design that leaked those writes would change the relay value or run a second command.
- **Unknown versus forwarded codes.** Codes just outside the forwarded ranges must not raise a request. Forwarded results must land in the correct byte order.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_CLEAR     = 8'h00;
  localparam byte_t OP_RELAY_SET = 8'h01;
  localparam byte_t OP_RELAY_GET = 8'h02;
  localparam byte_t OP_FW_VER    = 8'h0E;
  localparam byte_t OP_HW_VER    = 8'h0F;

  localparam int unsigned CMD_IDX = 2;
  localparam int unsigned N_ARG   = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FWD} exec_st_e;

  function automatic logic op_is_remote(byte_t op);
    return (op[7:4] == 4'h2) || (op[7:4] == 4'h4);
  endfunction
endpackage

// File: rtl/mbox_in_sync.sv
module mbox_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[i] <= '0;
      else     stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mbox_out_regs.sv
module mbox_out_regs
  import mbox_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  byte_t                  wr_data,
  input  logic                   busy,
  output logic [N_ARG-1:0][7:0]  arg_q,
  output logic                   start,
  output byte_t                  start_op
);
  logic accept;
  assign accept   = wr_en && !busy;
  assign start    = accept && (wr_addr == 2'(CMD_IDX));
  assign start_op = wr_data;

  for (genvar i = 0; i < N_ARG; i++) begin : g_arg
    always_ff @(posedge clk) begin
      if (rst)                                 arg_q[i] <= '0;
      else if (accept && wr_addr == 2'(i))     arg_q[i] <= wr_data;
    end
  end

  // R8: argument bytes frozen while a command runs
  p_args_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> $stable(arg_q));
endmodule

// File: rtl/mbox_exec.sv
module mbox_exec
  import mbox_pkg::*;
#(
  parameter int unsigned LATENCY    = 4,
  parameter logic [15:0] FW_VERSION = 16'h0A17,
  parameter logic [15:0] HW_VERSION = 16'h0B02
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  byte_t           start_op,
  input  logic [15:0]     arg,
  input  byte_t           iso_s,
  input  logic            sub_ack,
  input  logic [15:0]     sub_rdata,
  output logic            busy,
  output logic            sub_req,
  output byte_t           sub_cmd,
  output logic [15:0]     sub_arg,
  output byte_t           relay_q,
  output logic [3:0][7:0] in_bytes
);
  localparam int unsigned CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  exec_st_e         state;
  logic [CNT_W-1:0] cnt;
  byte_t            op_q;
  logic             commit;

  assign commit  = ((state == ST_WAIT) && (cnt == '0)) || ((state == ST_FWD) && sub_ack);
  assign busy    = (state != ST_IDLE);
  assign sub_req = (state == ST_FWD);
  assign sub_cmd = op_q;
  assign sub_arg = arg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      op_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          op_q <= start_op;
          if (op_is_remote(start_op)) state <= ST_FWD;
          else begin
            state <= ST_WAIT;
            cnt   <= CNT_W'(LATENCY - 1);
          end
        end
        ST_WAIT: if (cnt == '0) state <= ST_IDLE;
                 else           cnt   <= cnt - 1'b1;
        ST_FWD:  if (sub_ack)   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      relay_q  <= '0;
      in_bytes <= '0;
    end else if (commit) begin
      in_bytes[2] <= op_q;
      case (op_q)
        OP_CLEAR:     in_bytes[3] <= iso_s;
        OP_RELAY_SET: relay_q <= arg[7:0];
        OP_RELAY_GET: in_bytes[0] <= relay_q;
        OP_FW_VER:    {in_bytes[1], in_bytes[0]} <= FW_VERSION;
        OP_HW_VER:    {in_bytes[1], in_bytes[0]} <= HW_VERSION;
        default: if (op_is_remote(op_q)) {in_bytes[1], in_bytes[0]} <= sub_rdata;
      endcase
    end
  end

  // R6: request held until acknowledged, code stable meanwhile
  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (sub_req && !sub_ack) |=> sub_req);
  p_cmd_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (sub_req && !sub_ack) |=> $stable(sub_cmd));
  // R4: relays move only on a completing relay-set command
  p_relay_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(commit && op_q == OP_RELAY_SET) |=> $stable(relay_q));
  // R2: completion echoes the executed code
  p_echo_r2: assert property (@(posedge clk) disable iff (rst)
    commit |=> (in_bytes[2] == $past(op_q)));
  // R8: no new start is accepted while busy
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/mbox_cmd_engine.sv
module mbox_cmd_engine
  import mbox_pkg::*;
#(
  parameter int unsigned LATENCY     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [15:0] FW_VERSION  = 16'h0A17,
  parameter logic [15:0] HW_VERSION  = 16'h0B02
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic [7:0]  iso_in,
  output logic [7:0]  relay_out,
  output logic        sub_req,
  output logic [7:0]  sub_cmd,
  output logic [15:0] sub_arg,
  input  logic        sub_ack,
  input  logic [15:0] sub_rdata
);
  logic [N_ARG-1:0][7:0] arg_q;
  logic                  start, busy;
  byte_t                 start_op, iso_s;
  logic [3:0][7:0]       in_bytes;

  mbox_in_sync #(.W(8), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(iso_in), .q(iso_s));

  mbox_out_regs u_out (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .arg_q(arg_q), .start(start), .start_op(start_op));

  mbox_exec #(.LATENCY(LATENCY), .FW_VERSION(FW_VERSION), .HW_VERSION(HW_VERSION)) u_exec (
    .clk(clk), .rst(rst), .start(start), .start_op(start_op),
    .arg({arg_q[1], arg_q[0]}), .iso_s(iso_s), .sub_ack(sub_ack),
    .sub_rdata(sub_rdata), .busy(busy), .sub_req(sub_req), .sub_cmd(sub_cmd),
    .sub_arg(sub_arg), .relay_q(relay_out), .in_bytes(in_bytes));

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= in_bytes[rd_addr];
  end
endmodule

// File: tb/sim_mbox_cmd_engine.sv
module sim_mbox_cmd_engine;
  localparam logic [15:0] FW = 16'h0A17;
  localparam logic [15:0] HW = 16'h0B02;
  localparam int LAT = 4;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, iso_in = 0;
  logic [7:0] rd_data, relay_out, sub_cmd;
  logic sub_req, sub_ack = 0;
  logic [15:0] sub_arg, sub_rdata = 0;

  always #2 clk = ~clk;

  mbox_cmd_engine u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .iso_in(iso_in),
    .relay_out(relay_out), .sub_req(sub_req), .sub_cmd(sub_cmd), .sub_arg(sub_arg),
    .sub_ack(sub_ack), .sub_rdata(sub_rdata));

  int n_chk = 0, n_bad = 0;
  bit live = 0, saw_req = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_out [4];
  logic [7:0] m_in [4];
  logic [7:0] m_relay = 0, m_s1 = 0, m_s2 = 0, m_rd = 0, m_op = 0;
  int m_wait = 0;
  bit m_fwd = 0;

  function automatic bit fwd_code(logic [7:0] c);
    return (c >= 8'h20 && c <= 8'h2F) || (c >= 8'h40 && c <= 8'h4F);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_out[i] = 0; m_in[i] = 0; end
      m_relay = 0; m_s1 = 0; m_s2 = 0; m_rd = 0; m_op = 0; m_wait = 0; m_fwd = 0;
    end else begin
      bit was_busy, fin;
      was_busy = m_fwd || (m_wait > 0);
      fin = 0;
      m_rd = m_in[rd_addr];
      if (m_fwd) begin
        if (sub_ack) begin fin = 1; m_fwd = 0; end
      end else if (m_wait > 0) begin
        m_wait--;
        if (m_wait == 0) fin = 1;
      end
      if (fin) begin
        m_in[2] = m_op;
        if (m_op == 8'h00) m_in[3] = m_s2;
        else if (m_op == 8'h01) m_relay = m_out[0];
        else if (m_op == 8'h02) m_in[0] = m_relay;
        else if (m_op == 8'h0E) begin m_in[1] = FW[15:8]; m_in[0] = FW[7:0]; end
        else if (m_op == 8'h0F) begin m_in[1] = HW[15:8]; m_in[0] = HW[7:0]; end
        else if (fwd_code(m_op)) begin m_in[1] = sub_rdata[15:8]; m_in[0] = sub_rdata[7:0]; end
      end
      if (!was_busy && wr_en) begin
        m_out[wr_addr] = wr_data;
        if (wr_addr == 2) begin
          m_op = wr_data;
          if (fwd_code(wr_data)) m_fwd = 1; else m_wait = LAT;
        end
      end
      m_s2 = m_s1; m_s1 = iso_in;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R4 relay", relay_out, m_relay);
      chk("R10 rd_data", rd_data, m_rd);
      chk("R6 sub_req", sub_req, m_fwd);
      if (m_fwd) begin
        chk("R6 sub_cmd", sub_cmd, m_op);
        chk("R6 sub_arg", sub_arg, {m_out[1], m_out[0]});
      end
      if (sub_req) saw_req = 1;
    end
  end

  // sub-block responder: acknowledge on the second cycle of a request
  int rsp_cnt = 0;
  always @(negedge clk) begin
    if (rst) begin sub_ack <= 0; rsp_cnt = 0; end
    else if (sub_req && !sub_ack) begin
      if (rsp_cnt == 1) begin
        sub_ack <= 1; sub_rdata <= {sub_arg[7:0], sub_cmd}; rsp_cnt = 0;
      end else rsp_cnt++;
    end else sub_ack <= 0;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    while (m_fwd || m_wait > 0) @(negedge clk);
  endtask

  task automatic run(logic [7:0] op);
    wr(2, op); wait_idle();
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2 watchdog act=hung exp=complete");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    iso_in = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    // R1 reset state
    chk("R1 relay", relay_out, 8'h00);
    chk("R1 sub_req", sub_req, 1'b0);
    for (int i = 0; i < 4; i++) rd(2'(i), 8'h00, "R1 incoming");

    // R2 exact completion edge, with relay set (R4)
    wr(0, 8'h3C);
    @(negedge clk); rd_addr = 2;
    wr(2, 8'h01);
    repeat (4) @(negedge clk);
    chk("R2 echo not before commit", rd_data, 8'h00);
    @(negedge clk);
    chk("R2 echo after commit", rd_data, 8'h01);
    chk("R4 relay set", relay_out, 8'h3C);

    run(8'h02); rd(0, 8'h3C, "R4 relay readback");

    // R3 clear and input sample
    run(8'h00); rd(2, 8'h00, "R3 echo clear"); rd(3, 8'h5A, "R3 inputs");
    iso_in = 8'hC3; repeat (3) @(negedge clk);
    run(8'h00); rd(3, 8'hC3, "R3 inputs changed");
    rd(0, 8'h3C, "R3 byte0 untouched");

    // R5 versions
    run(8'h0E); rd(0, 8'h17, "R5 fw lo"); rd(1, 8'h0A, "R5 fw hi"); rd(2, 8'h0E, "R5 echo");
    run(8'h0F); rd(0, 8'h02, "R5 hw lo"); rd(1, 8'h0B, "R5 hw hi");

    // R9 repeat needs an intervening clear
    run(8'h0F); rd(2, 8'h0F, "R9 repeat same echo");
    run(8'h00); rd(2, 8'h00, "R9 cleared");
    rd(0, 8'h02, "R9 results held");
    run(8'h0F); rd(2, 8'h0F, "R9 repeat visible");

    // R6 forwarded commands
    saw_req = 0;
    wr(0, 8'h11); wr(1, 8'h22);
    run(8'h2C);
    chk("R6 request seen", saw_req, 1'b1);
    rd(0, 8'h2C, "R6 rdata lo"); rd(1, 8'h11, "R6 rdata hi"); rd(2, 8'h2C, "R6 echo");
    wr(0, 8'h77); run(8'h45);
    rd(0, 8'h45, "R6 second lo"); rd(1, 8'h77, "R6 second hi");

    // R7 unknown codes just outside forwarded ranges
    saw_req = 0;
    run(8'h30); rd(2, 8'h30, "R7 echo");
    run(8'h1F); rd(2, 8'h1F, "R7 echo 1F");
    rd(0, 8'h45, "R7 byte0 kept"); rd(1, 8'h77, "R7 byte1 kept");
    chk("R7 no request", saw_req, 1'b0);
    chk("R7 relay kept", relay_out, 8'h3C);

    // R8 writes while busy are dropped
    wr(0, 8'h3C); wr(2, 8'h01);
    wr(0, 8'hFF); wr(2, 8'h02);
    wait_idle();
    rd(2, 8'h01, "R8 second start ignored");
    chk("R8 relay", relay_out, 8'h3C);
    run(8'h01);
    chk("R8 arg not overwritten", relay_out, 8'h3C);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule